// File: doc/BRIEF.md
# EEPROM Programming-Status Read Multiplexer

This block sits on the read path of an EEPROM model. While the page write controller reports that an internal programming cycle is in progress, a read does not return plain array contents. Instead it carries two independent completion indicators. The top data bit returns the inverse of the top bit of the byte most recently written. The next bit flips its value from one read to the next. Once the busy flag clears, every bit of a read returns the array contents again.

A read is recognised when chip select and output enable are both low and write enable is high. The bus is driven only during such a read. A host can poll in either of two ways. It can read until the top bit matches what it wrote, or it can read twice and see whether the flipping bit has stopped. Polling may start at any point in the programming cycle. Reads may be framed by output enable, by chip select, or by both. Pin-level tri-state timing is outside this block.

Top module: `rd_status_mux`

## Requirements
- R1: `dout_en` is 1 exactly when `cs_n`=0, `oe_n`=0 and `we_n`=1. While `dout_en` is 0, `dout` is all zeros.
- R2: During a read with `busy`=1, `dout[7]` equals the inverse of `last_wr_byte[7]`.
- R3: With `busy`=1, `dout[6]` of each read differs from `dout[6]` of the previous busy read.
- R4: Within one read, while `busy` stays 1, `dout[6]` holds the same value in every cycle.
- R5: During a read with `busy`=0, `dout` equals `array_rdata` on all eight bits, in the same cycle that `busy` is sampled low.
- R6: The R3 alternation holds whether the read strobe is completed by the fall of `cs_n` or by the fall of `oe_n`.
- R7: A cycle with `cs_n`=0 and `we_n`=0 is not a read, and it does not advance the alternating bit: the next busy read still differs from the busy read before it.
- R8: A read that starts in the same cycle that `busy` rises already carries both status bits. Its `dout[6]` follows the R3 alternation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| busy | input | 1 | Internal programming cycle in progress |
| last_wr_byte | input | 8 | Last byte accepted by the page write controller |
| array_rdata | input | 8 | Array contents at the read address |
| dout | output | 8 | Read data bus |
| dout_en | output | 1 | Bus is being driven |

## Verification
The critical coincidence is the start of a read strobe and a change of the busy flag in the same cycle. The bench raises `busy` on the same clock edge at which a read begins. It checks that this read already shows the inverted top bit, and that its alternating bit differs from the last busy read. The bench also drops `busy` in the middle of an active read and expects true array data in that same cycle. The sweeps cover all 256 last-written values and all 256 array values. They mix reads completed by chip select and reads completed by output enable, and they insert write strobes between reads.

// File: rtl/rsm_pkg.sv
package rsm_pkg;

    localparam int unsigned RSM_DATA_W   = 8;
    localparam int unsigned RSM_POLL_BIT = RSM_DATA_W - 1;
    localparam int unsigned RSM_TOG_BIT  = RSM_DATA_W - 2;

    typedef struct packed {
        logic active;
        logic rise;
    } rd_strobe_t;

    typedef enum logic {
        OUT_ARRAY  = 1'b0,
        OUT_STATUS = 1'b1
    } out_src_e;

    function automatic logic is_read(input logic cs_n, input logic oe_n, input logic we_n);
        return !cs_n && !oe_n && we_n;
    endfunction

endpackage

// File: rtl/rsm_strobe.sv
module rsm_strobe
    import rsm_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       cs_n,
    input  logic       oe_n,
    input  logic       we_n,
    output rd_strobe_t strb
);

    logic active_c;
    logic active_q;

    assign active_c = is_read(cs_n, oe_n, we_n);

    always_ff @(posedge clk) begin
        if (rst) active_q <= 1'b0;
        else     active_q <= active_c;
    end

    assign strb.active = active_c;
    assign strb.rise   = active_c && !active_q;

    // R4: a read held across an edge carries no new rise
    a_r4_single_rise: assert property (@(posedge clk) disable iff (rst)
        strb.active |=> (strb.active -> !strb.rise));

endmodule

// File: rtl/rsm_toggle.sv
module rsm_toggle (
    input  logic clk,
    input  logic rst,
    input  logic busy,
    input  logic rd_rise,
    output logic tog_now
);

    logic tog_q;
    logic step;

    assign step = busy && rd_rise;

    always_ff @(posedge clk) begin
        if (rst)       tog_q <= 1'b0;
        else if (step) tog_q <= ~tog_q;
    end

    // the value of the new read is shown from its first cycle
    assign tog_now = tog_q ^ step;

    // R3: each busy read start advances the alternating bit
    a_r3_flip_per_read: assert property (@(posedge clk) disable iff (rst)
        (busy && rd_rise) |=> (tog_q != $past(tog_q)));

    // R7: nothing else moves it
    a_r7_hold_otherwise: assert property (@(posedge clk) disable iff (rst)
        !(busy && rd_rise) |=> $stable(tog_q));

endmodule

// File: rtl/rsm_mux.sv
module rsm_mux
    import rsm_pkg::*;
#(
    parameter int unsigned DATA_W   = RSM_DATA_W,
    parameter int unsigned POLL_BIT = DATA_W - 1,
    parameter int unsigned TOG_BIT  = DATA_W - 2
) (
    input  out_src_e          src,
    input  logic              drive,
    input  logic [DATA_W-1:0] arr,
    input  logic [DATA_W-1:0] last_wr,
    input  logic              tog,
    output logic [DATA_W-1:0] q
);

    for (genvar b = 0; b < DATA_W; b++) begin : g_bit
        logic status_v;
        if (b == POLL_BIT) begin : g_poll
            assign status_v = ~last_wr[b];
        end else if (b == TOG_BIT) begin : g_tog
            assign status_v = tog;
        end else begin : g_pass
            assign status_v = arr[b];
        end
        assign q[b] = drive && ((src == OUT_STATUS) ? status_v : arr[b]);
    end

endmodule

// File: rtl/rd_status_mux.sv
module rd_status_mux
    import rsm_pkg::*;
#(
    parameter int unsigned DATA_W = RSM_DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic              busy,
    input  logic [DATA_W-1:0] last_wr_byte,
    input  logic [DATA_W-1:0] array_rdata,
    output logic [DATA_W-1:0] dout,
    output logic              dout_en
);

    localparam int unsigned POLL_BIT = DATA_W - 1;
    localparam int unsigned TOG_BIT  = DATA_W - 2;

    rd_strobe_t strb;
    logic       tog_now;
    out_src_e   src;

    rsm_strobe u_strobe (
        .clk (clk), .rst (rst),
        .cs_n(cs_n), .oe_n(oe_n), .we_n(we_n),
        .strb(strb)
    );

    rsm_toggle u_toggle (
        .clk(clk), .rst(rst), .busy(busy),
        .rd_rise(strb.rise), .tog_now(tog_now)
    );

    assign src = busy ? OUT_STATUS : OUT_ARRAY;

    rsm_mux #(.DATA_W(DATA_W), .POLL_BIT(POLL_BIT), .TOG_BIT(TOG_BIT)) u_mux (
        .src(src), .drive(strb.active), .arr(array_rdata),
        .last_wr(last_wr_byte), .tog(tog_now), .q(dout)
    );

    assign dout_en = strb.active;

    // R1: released bus carries zeros
    a_r1_release: assert property (@(posedge clk) disable iff (rst)
        !dout_en |-> (dout == '0));

    // R2: inverted top bit while programming
    a_r2_poll_bit: assert property (@(posedge clk) disable iff (rst)
        (dout_en && busy) |-> (dout[POLL_BIT] != last_wr_byte[POLL_BIT]));

    // R5: true data once idle
    a_r5_true_data: assert property (@(posedge clk) disable iff (rst)
        (dout_en && !busy) |-> (dout == array_rdata));

    // R4: alternating bit steady across one busy read
    a_r4_bit_steady: assert property (@(posedge clk) disable iff (rst)
        (dout_en && busy && $past(dout_en) && $past(busy) && $past(!rst))
        |-> (dout[TOG_BIT] == $past(dout[TOG_BIT])));

endmodule

// File: tb/sim_rd_status_mux.sv
`timescale 1ns/1ps
module sim_rd_status_mux;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cs_n = 1'b1, oe_n = 1'b1, we_n = 1'b1, busy = 1'b0;
    logic [7:0] last_wr_byte = '0, array_rdata = '0;
    logic [7:0] dout;
    logic       dout_en;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    always #2.5 clk = ~clk;

    rd_status_mux u0 (
        .clk(clk), .rst(rst), .cs_n(cs_n), .oe_n(oe_n), .we_n(we_n),
        .busy(busy), .last_wr_byte(last_wr_byte), .array_rdata(array_rdata),
        .dout(dout), .dout_en(dout_en)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    // read: strobe completed by cs (via_cs=1) or by oe; samples first and second cycle
    task automatic do_read(input bit via_cs, output logic [7:0] d_a, output logic [7:0] d_b);
        @(negedge clk);
        if (via_cs) oe_n = 1'b0; else cs_n = 1'b0;
        @(negedge clk);
        #0.5 chk("R1 no drive before strobe complete", {7'd0, dout_en}, 8'd0);
        if (via_cs) cs_n = 1'b0; else oe_n = 1'b0;
        #1 d_a = dout;
        chk("R1 drive during read", {7'd0, dout_en}, 8'd1);
        @(posedge clk);
        #1 d_b = dout;
        @(negedge clk);
        cs_n = 1'b1; oe_n = 1'b1;
    endtask

    task automatic do_write();
        @(negedge clk);
        cs_n = 1'b0; we_n = 1'b0; oe_n = 1'b0;
        #1 chk("R7 write strobe not a read", {dout_en, 7'd0} | dout, 8'd0);
        @(negedge clk);
        cs_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
    endtask

    initial begin
        #190000;
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] da, db;
        logic       prev6;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1 chk("R1 reset idle bus", dout, 8'd0);
        chk("R1 reset no enable", {7'd0, dout_en}, 8'd0);

        // idle sweep over all array values
        for (int a = 0; a < 256; a++) begin
            array_rdata = 8'(a);
            do_read(a[0], da, db);
            chk("R5 idle read first cycle", da, 8'(a));
            chk("R5 idle read second cycle", db, 8'(a));
        end

        // R8: busy rises on the same edge the read begins
        @(negedge clk);
        last_wr_byte = 8'h80; array_rdata = 8'h15;
        oe_n = 1'b0;
        @(negedge clk);
        busy = 1'b1; cs_n = 1'b0;
        #1 da = dout;
        chk("R8 poll bit on first busy cycle", {7'd0, da[7]}, 8'd0);
        chk("R8 low bits pass", {2'b0, da[5:0]}, 8'h15);
        @(posedge clk);
        #1 db = dout;
        chk("R4 bit6 steady first read", {7'd0, db[6]}, {7'd0, da[6]});
        @(negedge clk);
        cs_n = 1'b1; oe_n = 1'b1;
        prev6 = da[6];

        // busy sweep over all last-written values
        for (int v = 0; v < 256; v++) begin
            last_wr_byte = 8'(v);
            array_rdata  = 8'(v) ^ 8'h3C;
            if ((v % 16) == 5) do_write();
            do_read(v[0], da, db);
            chk("R2 inverted poll bit", {7'd0, da[7]}, {7'd0, ~last_wr_byte[7]});
            chk("R4 bit6 steady in read", {7'd0, db[6]}, {7'd0, da[6]});
            if (v[0]) chk("R6 alternation via cs", {7'd0, da[6]}, {7'd0, ~prev6});
            else      chk("R3 R6 alternation via oe", {7'd0, da[6]}, {7'd0, ~prev6});
            prev6 = da[6];
        end

        // busy falls mid-read: true data in the same cycle
        array_rdata = 8'hA5; last_wr_byte = 8'hA5;
        @(negedge clk);
        cs_n = 1'b0; oe_n = 1'b0;
        @(negedge clk);
        busy = 1'b0;
        #1 chk("R5 true data at busy fall", dout, 8'hA5);
        @(negedge clk);
        cs_n = 1'b1; oe_n = 1'b1;
        #1 chk("R1 released after read", dout, 8'd0);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule